// File: doc/BRIEF.md
# Counting Bloom Filter with Memory-Held Counts

This block keeps one saturating count per entry of a counting Bloom filter and answers the question "is this entry's count zero?". A caller hands it a command (increment, decrement, probe or no-op) together with an already hashed entry index. Increments and decrements go through a read-modify-write pass. The count is read from a single-port synchronous memory, stepped by one in the block's only up/down adder, and written back to the same entry. A zero answer to a probe means the element is certainly absent; a nonzero answer means the caller must search the full set.

Beside the count memory sits one zero-flag bit per entry. This flag is rewritten only when an update moves a count onto or off zero. A probe looks at the flag alone and never touches the count memory, so it completes in one cycle while an update keeps the block busy for three. Stepping past the largest count, or below zero, leaves the count alone and is reported with an error bit.

Commands use a valid/ready handshake. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only when the controller is idle, so the caller must hold its command, unchanged, until that edge. Responses have no back-pressure: `resp_valid` is a one-cycle pulse that the caller must take when it appears.

Top module: `cbf_sram_core`

## Requirements
- R1: While `rst` is high and for the first DEPTH rising edges after it falls, `cmd_ready` and `resp_valid` are low, because the count memory is being swept to zero. After the sweep, a probe of every entry reports zero.
- R2: A probe (`cmd_op` = 2'b11) taken on an edge gives `resp_valid` high in the next cycle, with `resp_zero` = 1 exactly when that entry's count is zero and `resp_err` = 0. `cmd_ready` stays high, so probes can be issued back to back.
- R3: An increment (`cmd_op` = 2'b01) adds one to the indexed count. `cmd_ready` is low for the three cycles after acceptance. In the fourth cycle `resp_valid` pulses with `resp_zero` = 0, and `cmd_ready` is high again.
- R4: A decrement (`cmd_op` = 2'b10) subtracts one from the indexed count with the same timing as R3. On its response, `resp_zero` is 1 exactly when the new count is zero, and later probes agree with it.
- R5: An increment at the all-ones count leaves the count unchanged and gives `resp_err` = 1 with its response. `resp_err` is never high without `resp_valid`.
- R6: A decrement at zero leaves the count at zero and gives `resp_err` = 1 and `resp_zero` = 1 with its response.
- R7: An update changes only the addressed entry: probes of other entries keep their earlier answers.
- R8: A no-op (`cmd_op` = 2'b00) is accepted without any response or state change. While the block is busy, `cmd_valid` is ignored, and a command dropped before `cmd_ready` returns has no effect. `resp_valid` is only ever high while `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; starts the clearing sweep |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle; a command is taken when both are high |
| cmd_op | input | 2 | 00 no-op, 01 increment, 10 decrement, 11 probe |
| cmd_idx | input | $clog2(DEPTH) | Hashed entry index |
| resp_valid | output | 1 | One-cycle done pulse for a probe or an update |
| resp_zero | output | 1 | Entry count is zero (after the update, for updates) |
| resp_err | output | 1 | Update saturated at either end; count kept |

## Verification
The bound checker watches the handshake timing on every cycle: the one-cycle probe turnaround, the exact three-cycle busy window of an update, the silence after a no-op, responses appearing only while ready, and error bits appearing only with a done pulse. The count values themselves are checked only by the bench scenarios. These cover saturation at both ends, the zero flag following a count onto and off zero, isolation between entries, a command dropped while the block is busy, and the clearing sweep. All of these depend on the history of one entry, and only a reference model in the bench can track that history.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_INC   = 2'b01,
    OP_DEC   = 2'b10,
    OP_PROBE = 2'b11
  } cbf_op_e;

  typedef enum logic [2:0] {
    ST_SWEEP,
    ST_IDLE,
    ST_READ,
    ST_MODIFY,
    ST_WRITE
  } cbf_state_e;

endpackage

// File: rtl/cbf_count_ram.sv
module cbf_count_ram #(
  parameter int DEPTH = 1024,
  parameter int CW    = 15,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [IW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata
);

  logic [CW-1:0] mem [DEPTH];

  // single port: a write takes the port, otherwise a gated read
  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end else if (re) begin
      rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/cbf_zero_flags.sv
module cbf_zero_flags #(
  parameter int DEPTH = 1024,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic          wbit,
  input  logic [IW-1:0] raddr,
  output logic          rbit
);

  logic [DEPTH-1:0] flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '1;
    end else if (we) begin
      flags[waddr] <= wbit;
    end
  end

  assign rbit = flags[raddr];

endmodule

// File: rtl/cbf_updown.sv
module cbf_updown #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          up,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] q,
  output logic          err,
  output logic          old_zero,
  output logic          new_zero
);

  logic          din_zero;
  logic          din_full;
  logic          sat;
  logic [CW-1:0] stepped;

  always_comb begin
    din_zero = (din == '0);
    din_full = &din;
    sat      = up ? din_full : din_zero;
    stepped  = up ? din + CW'(1) : din - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= '0;
      err      <= 1'b0;
      old_zero <= 1'b1;
    end else if (load) begin
      q        <= sat ? din : stepped;
      err      <= sat;
      old_zero <= din_zero;
    end
  end

  assign new_zero = (q == '0);

endmodule

// File: rtl/cbf_ctrl.sv
module cbf_ctrl
  import cbf_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  cbf_op_e       cmd_op,
  input  logic [IW-1:0] cmd_idx,
  output logic          cmd_ready,
  output logic          ram_we,
  output logic          ram_re,
  output logic          ram_clear,
  output logic [IW-1:0] ram_addr,
  output logic          cnt_load,
  output logic          cnt_up,
  input  logic          cnt_err,
  input  logic          cnt_old_zero,
  input  logic          cnt_new_zero,
  input  logic          flag_rbit,
  output logic          flag_we,
  output logic [IW-1:0] flag_waddr,
  output logic          flag_wbit,
  output logic          resp_valid,
  output logic          resp_zero,
  output logic          resp_err
);

  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

  cbf_state_e    state;
  logic [IW-1:0] sweep_idx;
  logic [IW-1:0] idx_q;
  logic          up_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_SWEEP;
      sweep_idx  <= '0;
      idx_q      <= '0;
      up_q       <= 1'b0;
      resp_valid <= 1'b0;
      resp_zero  <= 1'b0;
      resp_err   <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      unique case (state)
        ST_SWEEP: begin
          sweep_idx <= sweep_idx + IW'(1);
          if (sweep_idx == LAST_IDX) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (cmd_valid) begin
            unique case (cmd_op)
              OP_PROBE: begin
                resp_valid <= 1'b1;
                resp_zero  <= flag_rbit;
              end
              OP_INC, OP_DEC: begin
                idx_q <= cmd_idx;
                up_q  <= (cmd_op == OP_INC);
                state <= ST_READ;
              end
              default: ;
            endcase
          end
        end
        ST_READ:   state <= ST_MODIFY;
        ST_MODIFY: state <= ST_WRITE;
        ST_WRITE: begin
          state      <= ST_IDLE;
          resp_valid <= 1'b1;
          resp_zero  <= cnt_new_zero;
          resp_err   <= cnt_err;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_ready  = (state == ST_IDLE);
    ram_clear  = (state == ST_SWEEP);
    ram_we     = ram_clear || (state == ST_WRITE);
    ram_re     = (state == ST_READ);
    ram_addr   = ram_clear ? sweep_idx : idx_q;
    cnt_load   = (state == ST_MODIFY);
    cnt_up     = up_q;
    // flag only rewritten when the count crosses zero
    flag_we    = (state == ST_WRITE) && (cnt_old_zero != cnt_new_zero);
    flag_waddr = idx_q;
    flag_wbit  = cnt_new_zero;
  end

endmodule

// File: rtl/cbf_sram_core.sv
module cbf_sram_core
  import cbf_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int CW    = 15,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [IW-1:0] cmd_idx,
  output logic          resp_valid,
  output logic          resp_zero,
  output logic          resp_err
);

  logic          ram_we;
  logic          ram_re;
  logic          ram_clear;
  logic [IW-1:0] ram_addr;
  logic [CW-1:0] ram_wdata;
  logic [CW-1:0] ram_rdata;
  logic          cnt_load;
  logic          cnt_up;
  logic [CW-1:0] cnt_q;
  logic          cnt_err;
  logic          cnt_old_zero;
  logic          cnt_new_zero;
  logic          flag_we;
  logic [IW-1:0] flag_waddr;
  logic          flag_wbit;
  logic          flag_rbit;

  assign ram_wdata = ram_clear ? '0 : cnt_q;

  cbf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cbf_op_e'(cmd_op)),
    .cmd_idx     (cmd_idx),
    .cmd_ready   (cmd_ready),
    .ram_we      (ram_we),
    .ram_re      (ram_re),
    .ram_clear   (ram_clear),
    .ram_addr    (ram_addr),
    .cnt_load    (cnt_load),
    .cnt_up      (cnt_up),
    .cnt_err     (cnt_err),
    .cnt_old_zero(cnt_old_zero),
    .cnt_new_zero(cnt_new_zero),
    .flag_rbit   (flag_rbit),
    .flag_we     (flag_we),
    .flag_waddr  (flag_waddr),
    .flag_wbit   (flag_wbit),
    .resp_valid  (resp_valid),
    .resp_zero   (resp_zero),
    .resp_err    (resp_err)
  );

  cbf_count_ram #(.DEPTH(DEPTH), .CW(CW)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .re   (ram_re),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .rdata(ram_rdata)
  );

  cbf_updown #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (cnt_load),
    .up      (cnt_up),
    .din     (ram_rdata),
    .q       (cnt_q),
    .err     (cnt_err),
    .old_zero(cnt_old_zero),
    .new_zero(cnt_new_zero)
  );

  cbf_zero_flags #(.DEPTH(DEPTH)) u_flags (
    .clk  (clk),
    .rst  (rst),
    .we   (flag_we),
    .waddr(flag_waddr),
    .wbit (flag_wbit),
    .raddr(cmd_idx),
    .rbit (flag_rbit)
  );

endmodule

// File: rtl/cbf_sram_core_chk.sv
module cbf_sram_core_chk #(
  parameter int DEPTH = 1024,
  parameter int CW    = 15,
  localparam int IW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [IW-1:0] cmd_idx,
  input logic          resp_valid,
  input logic          resp_zero,
  input logic          resp_err
);

  logic take;
  assign take = cmd_valid && cmd_ready;

  assert_update_three_cycles_R3: assert property (@(posedge clk) disable iff (rst)
    (take && (cmd_op == 2'b01 || cmd_op == 2'b10))
      |=> !cmd_ready ##1 !cmd_ready ##1 !cmd_ready ##1 (cmd_ready && resp_valid));

  assert_probe_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (take && cmd_op == 2'b11) |=> (resp_valid && cmd_ready && !resp_err));

  assert_nop_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (take && cmd_op == 2'b00) |=> !resp_valid);

  assert_resp_only_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> cmd_ready);

  assert_err_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> resp_valid);

endmodule

bind cbf_sram_core cbf_sram_core_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (.*);

// File: tb/sim_cbf_sram_core.sv
module sim_cbf_sram_core;

  localparam int DEPTH = 16;
  localparam int CW    = 3;
  localparam int IW    = $clog2(DEPTH);
  localparam int MAXC  = (1 << CW) - 1;
  localparam logic [1:0] NOP = 2'b00, INC = 2'b01, DEC = 2'b10, PRB = 2'b11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'b00;
  logic [IW-1:0] cmd_idx = '0;
  logic          resp_valid;
  logic          resp_zero;
  logic          resp_err;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cbf_sram_core #(.DEPTH(DEPTH), .CW(CW)) u0 (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_idx),
    .resp_valid(resp_valid),
    .resp_zero (resp_zero),
    .resp_err  (resp_err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // issue one command; lat = negedges until resp_valid (8 means none)
  task automatic issue(input logic [1:0] op, input int idx, output int lat,
                       output logic z, output logic e, output logic busy_ok);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_idx   = IW'(idx);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = NOP;
    lat = 1;
    busy_ok = 1'b1;
    while (!resp_valid && lat < 8) begin
      if (cmd_ready) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    z = resp_zero;
    e = resp_err;
  endtask

  task automatic probe_expect(input string req, input int idx, input int exp_zero);
    int lat; logic z, e, b;
    issue(PRB, idx, lat, z, e, b);
    check(req, $sformatf("probe[%0d] latency", idx), lat, 1);
    check(req, $sformatf("probe[%0d] zero", idx), int'(z), exp_zero);
    check(req, $sformatf("probe[%0d] ready kept", idx), int'(cmd_ready), 1);
  endtask

  task automatic update_expect(input string req, input logic [1:0] op, input int idx,
                               input int exp_zero, input int exp_err);
    int lat; logic z, e, b;
    issue(op, idx, lat, z, e, b);
    check(req, $sformatf("update[%0d] latency", idx), lat, 4);
    check(req, $sformatf("update[%0d] busy window", idx), int'(b), 1);
    check(req, $sformatf("update[%0d] zero", idx), int'(z), exp_zero);
    check(req, $sformatf("update[%0d] err", idx), int'(e), exp_err);
  endtask

  task automatic t_reset_R1();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", int'(cmd_ready), 0);
    check("R1", "resp in reset", int'(resp_valid), 0);
    rst = 1'b0;
    repeat (DEPTH - 1) @(posedge clk);
    @(negedge clk);
    check("R1", "ready before sweep end", int'(cmd_ready), 0);
    @(posedge clk);
    @(negedge clk);
    check("R1", "ready after sweep", int'(cmd_ready), 1);
    for (int i = 0; i < DEPTH; i++) probe_expect("R1", i, 1);
  endtask

  task automatic t_probe_R2();
    probe_expect("R2", 3, 1);
    probe_expect("R2", 0, 1);
    probe_expect("R2", DEPTH - 1, 1);
  endtask

  task automatic t_inc_R3();
    update_expect("R3", INC, 5, 0, 0);
    probe_expect("R3", 5, 0);
    update_expect("R3", INC, 5, 0, 0);
  endtask

  task automatic t_dec_R4();
    update_expect("R4", DEC, 5, 0, 0);
    probe_expect("R4", 5, 0);
    update_expect("R4", DEC, 5, 1, 0);
    probe_expect("R4", 5, 1);
  endtask

  task automatic t_overflow_R5();
    for (int i = 0; i < MAXC; i++) update_expect("R5", INC, 9, 0, 0);
    update_expect("R5", INC, 9, 0, 1);
    for (int i = 0; i < MAXC - 1; i++) update_expect("R5", DEC, 9, 0, 0);
    update_expect("R5", DEC, 9, 1, 0);
  endtask

  task automatic t_underflow_R6();
    update_expect("R6", DEC, 2, 1, 1);
    probe_expect("R6", 2, 1);
    update_expect("R6", INC, 2, 0, 0);
    update_expect("R6", DEC, 2, 1, 0);
  endtask

  task automatic t_isolation_R7();
    update_expect("R7", INC, 1, 0, 0);
    probe_expect("R7", 0, 1);
    probe_expect("R7", 2, 1);
    probe_expect("R7", 1, 0);
  endtask

  task automatic t_handshake_R8();
    int lat; logic z, e, b;
    issue(NOP, 4, lat, z, e, b);
    check("R8", "no-op gives no response", lat, 8);
    probe_expect("R8", 4, 1);
    // drive a competing command while busy, drop it as ready returns
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = INC; cmd_idx = IW'(6);
    @(negedge clk);
    cmd_idx = IW'(12);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check("R8", "busy command response", int'(resp_valid), 1);
    cmd_valid = 1'b0; cmd_op = NOP;
    probe_expect("R8", 12, 1);
    probe_expect("R8", 6, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    t_reset_R1();
    t_probe_R2();
    t_inc_R3();
    t_dec_R4();
    t_overflow_R5();
    t_underflow_R6();
    t_isolation_R7();
    t_handshake_R8();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule